// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers every exception and interrupt request that a small microcontroller core can see in one cycle. The requests are reset causes, nonmaskable traps and nineteen maskable peripheral or pin requests. The block applies the condition-code masks and the per-source enables, then resolves a single winner. It hands the CPU sequencer a registered 5-bit vector index and a pending strobe, and the sequencer uses the index to fetch its vector.

Software can pick one maskable source to move to the head of the maskable order by writing that source's index into a priority-select register. The block guards this register: a write takes effect only while the global interrupt mask is set and the index names a real source. Any other write is dropped and flagged for one cycle.

Top module: `int_prio_ctrl`

## Requirements
- R1: Reset causes outrank everything. On resetCause, bit 0 (power-on/external) gives vector 0, bit 1 (clock monitor) gives vector 1 and bit 2 (watchdog) gives vector 2. The lower bit wins when several bits are set.
- R2: Nonmaskable requests outrank all maskable ones. On nmiReq, bit 0 (pin, honoured only while xMask is 0) gives vector 3, bit 1 (illegal opcode) gives vector 4 and bit 2 (software trap) gives vector 5, with the lower bit winning. Bits 1 and 2 are never masked.
- R3: A maskable request is ignored while iMask is 1.
- R4: Maskable sources 1 to 18 also need their localEn bit set. Source 0 (external pin) has no local enable.
- R5: Without promotion, the lowest active maskable index wins. Source k < 11 maps to vector 6+k. Source k >= 11 maps to vector 17+(k-11)/2, so sources 11/12, 13/14, 15/16 and 17/18 share vectors.
- R6: When the source named by the priority-select register is active, it beats every other maskable source. Nonmaskable requests and reset causes still outrank it.
- R7: A write whose wrData is above 18, or that arrives while iMask is 0, leaves the register unchanged and sets wrReject high for exactly the following cycle.
- R8: After reset the register selects source 0, reqPending is 0, vecIdx is 31 and wrReject is 0.
- R9: The outputs update one clock after the inputs. reqPending is 1 exactly when some unmasked request was active, and vecIdx is 31 when none was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetCause | input | 3 | Reset cause requests |
| nmiReq | input | 3 | Nonmaskable requests |
| maskReq | input | 19 | Maskable request lines |
| localEn | input | 19 | Per-source local enables (bit 0 unused) |
| iMask | input | 1 | Global interrupt mask bit |
| xMask | input | 1 | Pin nonmaskable mask bit |
| wrEn | input | 1 | Priority-select register write strobe |
| wrData | input | 5 | Source index to promote |
| reqPending | output | 1 | An unmasked request is pending |
| vecIdx | output | 5 | Selected vector index |
| wrReject | output | 1 | Previous cycle's write was refused |

## Verification
The hardest case to reach from the ports is a promotion that actually changes the winner. It needs an accepted write made while iMask is set, then iMask must be cleared while a lower-index source and the promoted one request together. The stimulus also follows a refused write, made with iMask clear, with that same two-source pattern to show the old selection survived. Ties inside a shared vector pair and nonmaskable requests arriving over a promoted source complete the ordering cases.

// File: rtl/int_prio_pkg.sv
package int_prio_pkg;
  localparam int VEC_W      = 5;
  localparam int MASK_BASE  = 6;
  localparam int SHARE_FROM = 11;
  localparam logic [VEC_W-1:0] IDLE_VEC = '1;

  typedef struct packed {
    logic load;
    logic reject;
  } wrStrobe_t;

  function automatic logic [VEC_W-1:0] srcVec(input int k);
    int v;
    if (k < SHARE_FROM) v = MASK_BASE + k;
    else v = MASK_BASE + SHARE_FROM + (k - SHARE_FROM) / 2;
    return VEC_W'(v);
  endfunction
endpackage

// File: rtl/int_prio_ctl.sv
module int_prio_ctl
  import int_prio_pkg::*;
#(
  parameter int NUM_SRC = 19,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic             wrEn,
  input  logic             iMask,
  input  logic [SEL_W-1:0] wrData,
  output wrStrobe_t        strobe
);
  logic inRange;

  always_comb begin
    inRange       = (int'(wrData) < NUM_SRC);
    strobe.load   = wrEn & iMask & inRange;
    strobe.reject = wrEn & ~(iMask & inRange);
  end
endmodule

// File: rtl/int_prio_dp.sv
module int_prio_dp
  import int_prio_pkg::*;
#(
  parameter int NUM_SRC = 19,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         resetCause,
  input  logic [2:0]         nmiReq,
  input  logic [NUM_SRC-1:0] maskReq,
  input  logic [NUM_SRC-1:0] localEn,
  input  logic               iMask,
  input  logic               xMask,
  input  logic [SEL_W-1:0]   wrData,
  input  wrStrobe_t          strobe,
  output logic               reqPending,
  output logic [VEC_W-1:0]   vecIdx,
  output logic               wrReject
);
  localparam int PAD = 2 ** SEL_W;

  logic [SEL_W-1:0]   hpSel;
  logic [NUM_SRC-1:0] active;
  logic [PAD-1:0]     activePad;
  logic [SEL_W-1:0]   dfltIdx;
  logic               anyMask, promoHit, pinNmi;
  logic [VEC_W-1:0]   nextVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hpSel <= '0;
    else if (strobe.load) hpSel <= wrData;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (k == 0) begin : g_pin
      assign active[k] = maskReq[k] & ~iMask;
    end else begin : g_per
      assign active[k] = maskReq[k] & localEn[k] & ~iMask;
    end
  end

  assign activePad = PAD'(active);
  assign anyMask   = |active;
  assign promoHit  = activePad[hpSel];
  assign pinNmi    = nmiReq[0] & ~xMask;

  always_comb begin
    dfltIdx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (active[k]) dfltIdx = SEL_W'(k);
  end

  always_comb begin
    if (resetCause[0])      nextVec = VEC_W'(0);
    else if (resetCause[1]) nextVec = VEC_W'(1);
    else if (resetCause[2]) nextVec = VEC_W'(2);
    else if (pinNmi)        nextVec = VEC_W'(3);
    else if (nmiReq[1])     nextVec = VEC_W'(4);
    else if (nmiReq[2])     nextVec = VEC_W'(5);
    else if (promoHit)      nextVec = srcVec(int'(hpSel));
    else if (anyMask)       nextVec = srcVec(int'(dfltIdx));
    else                    nextVec = IDLE_VEC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecIdx     <= IDLE_VEC;
      reqPending <= 1'b0;
      wrReject   <= 1'b0;
    end else begin
      vecIdx     <= nextVec;
      reqPending <= (|resetCause) | pinNmi | (|nmiReq[2:1]) | anyMask;
      wrReject   <= strobe.reject;
    end
  end
endmodule

// File: rtl/int_prio_ctrl.sv
module int_prio_ctrl
  import int_prio_pkg::*;
#(
  parameter int NUM_SRC = 19,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         resetCause,
  input  logic [2:0]         nmiReq,
  input  logic [NUM_SRC-1:0] maskReq,
  input  logic [NUM_SRC-1:0] localEn,
  input  logic               iMask,
  input  logic               xMask,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrData,
  output logic               reqPending,
  output logic [VEC_W-1:0]   vecIdx,
  output logic               wrReject
);
  wrStrobe_t strobe;

  int_prio_ctl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_ctl (
    .wrEn(wrEn), .iMask(iMask), .wrData(wrData), .strobe(strobe)
  );

  int_prio_dp #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .resetCause(resetCause), .nmiReq(nmiReq),
    .maskReq(maskReq), .localEn(localEn), .iMask(iMask), .xMask(xMask),
    .wrData(wrData), .strobe(strobe), .reqPending(reqPending),
    .vecIdx(vecIdx), .wrReject(wrReject)
  );
endmodule

// File: rtl/int_prio_chk.sv
module int_prio_chk #(
  parameter int NUM_SRC = 19,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         resetCause,
  input logic [2:0]         nmiReq,
  input logic [NUM_SRC-1:0] maskReq,
  input logic [NUM_SRC-1:0] localEn,
  input logic               iMask,
  input logic               xMask,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrData,
  input logic               reqPending,
  input logic [4:0]         vecIdx,
  input logic               wrReject
);
  a_r1_por_first: assert property (@(posedge clk) disable iff (!rstN)
    resetCause[0] |=> (vecIdx == 5'd0));

  a_r2_pin_nmi: assert property (@(posedge clk) disable iff (!rstN)
    (resetCause == 3'b0 && nmiReq[0] && !xMask) |=> (vecIdx == 5'd3));

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (iMask && resetCause == 3'b0 && nmiReq[2:1] == 2'b0 && !(nmiReq[0] && !xMask))
      |=> !reqPending);

  a_r7_reject_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !iMask) |=> wrReject);

  a_r7_no_write_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !wrReject);

  a_r9_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    !reqPending |-> (vecIdx == 5'd31));
endmodule

bind int_prio_ctrl int_prio_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_int_prio_ctrl.sv
`timescale 1ns/1ps
module tb_int_prio_ctrl;
  localparam int NS = 19;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] resetCause = '0, nmiReq = '0;
  logic [NS-1:0] maskReq = '0, localEn = '0;
  logic iMask = 1'b1, xMask = 1'b1, wrEn = 1'b0;
  logic [4:0] wrData = '0;
  logic reqPending, wrReject;
  logic [4:0] vecIdx;

  int tests = 0, fails = 0;
  int shadowSel = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] vec;
    logic       pend;
    logic       rej;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  int_prio_ctrl dut (.*);

  function automatic logic [4:0] mapSrc(int k);
    return (k < 11) ? 5'(6 + k) : 5'(17 + (k - 11) / 2);
  endfunction

  task automatic step(input logic [2:0] rc, input logic [2:0] nm,
                      input logic [NS-1:0] mr, input logic [NS-1:0] le,
                      input logic im, input logic xm, input logic we,
                      input logic [4:0] wd, input string tag);
    exp_t e;
    logic [NS-1:0] act;
    bit ok;
    @(negedge clk);
    resetCause = rc; nmiReq = nm; maskReq = mr; localEn = le;
    iMask = im; xMask = xm; wrEn = we; wrData = wd;
    for (int k = 0; k < NS; k++) act[k] = mr[k] && !im && (k == 0 || le[k]);
    e.tag = tag;
    e.pend = (rc != 0) || (nm[0] && !xm) || nm[1] || nm[2] || (act != 0);
    if (rc[0]) e.vec = 0;
    else if (rc[1]) e.vec = 1;
    else if (rc[2]) e.vec = 2;
    else if (nm[0] && !xm) e.vec = 3;
    else if (nm[1]) e.vec = 4;
    else if (nm[2]) e.vec = 5;
    else if (act[shadowSel]) e.vec = mapSrc(shadowSel);
    else begin
      e.vec = 31;
      for (int k = NS - 1; k >= 0; k--) if (act[k]) e.vec = mapSrc(k);
    end
    ok = we && im && (int'(wd) < NS);
    e.rej = we && !ok;
    q.push_back(e);
    if (ok) shadowSel = int'(wd);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        tests++;
        if (vecIdx !== e.vec || reqPending !== e.pend || wrReject !== e.rej) begin
          fails++;
          $display("FAIL %s: vec=%0d pend=%0b rej=%0b expected vec=%0d pend=%0b rej=%0b",
                   e.tag, vecIdx, reqPending, wrReject, e.vec, e.pend, e.rej);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [NS-1:0] allEn = '1;
    repeat (3) @(posedge clk);
    #1;
    tests++;
    if (reqPending !== 1'b0 || vecIdx !== 5'd31 || wrReject !== 1'b0) begin
      fails++;
      $display("FAIL R8: pend=%0b vec=%0d rej=%0b expected pend=0 vec=31 rej=0",
               reqPending, vecIdx, wrReject);
    end
    @(negedge clk); rstN = 1'b1;
    // R8 default select is source 0; R9 idle
    step(3'b000, 3'b000, '0, '0, 1'b0, 1'b1, 1'b0, 5'd0, "R9 idle");
    step(3'b000, 3'b000, 19'h00009, '0, 1'b0, 1'b1, 1'b0, 5'd0, "R8 default top src0");
    // R1 reset ordering
    step(3'b111, 3'b111, '1, allEn, 1'b0, 1'b0, 1'b0, 5'd0, "R1 por wins");
    step(3'b110, 3'b111, '1, allEn, 1'b0, 1'b0, 1'b0, 5'd0, "R1 clkmon");
    step(3'b100, 3'b111, '1, allEn, 1'b0, 1'b0, 1'b0, 5'd0, "R1 cop");
    // R2 nonmaskable
    step(3'b000, 3'b111, '1, allEn, 1'b0, 1'b0, 1'b0, 5'd0, "R2 pin nmi");
    step(3'b000, 3'b111, '1, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R2 pin masked by X");
    step(3'b000, 3'b101, '1, allEn, 1'b1, 1'b1, 1'b0, 5'd0, "R2 swi unmaskable");
    step(3'b000, 3'b001, '0, '0, 1'b0, 1'b1, 1'b0, 5'd0, "R2 only masked pin");
    // R3 global mask
    step(3'b000, 3'b000, '1, allEn, 1'b1, 1'b1, 1'b0, 5'd0, "R3 I set blocks");
    // R4 local enables
    step(3'b000, 3'b000, 19'h00030, 19'h00020, 1'b0, 1'b1, 1'b0, 5'd0, "R4 src4 disabled");
    step(3'b000, 3'b000, 19'h00001, 19'h00000, 1'b0, 1'b1, 1'b0, 5'd0, "R4 src0 no enable");
    // R5 default order and shared vectors
    step(3'b000, 3'b000, 19'h00400, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R5 src10 vec16");
    step(3'b000, 3'b000, 19'h01000, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R5 src12 shared vec17");
    step(3'b000, 3'b000, 19'h40000, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R5 src18 vec20");
    step(3'b000, 3'b000, 19'h60800, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R5 lowest wins");
    // R6 promotion: accepted write then contest
    step(3'b000, 3'b000, '0, allEn, 1'b1, 1'b1, 1'b1, 5'd14, "R6 write accepted");
    step(3'b000, 3'b000, 19'h04004, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R6 promoted src14 wins");
    step(3'b000, 3'b100, 19'h04004, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R6 nmi over promoted");
    step(3'b000, 3'b000, 19'h00004, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R6 promoted idle fallback");
    // R7 refused writes
    step(3'b000, 3'b000, '0, allEn, 1'b0, 1'b1, 1'b1, 5'd3, "R7 write while I clear");
    step(3'b000, 3'b000, 19'h04008, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R7 register kept");
    step(3'b000, 3'b000, '0, allEn, 1'b1, 1'b1, 1'b1, 5'd25, "R7 out of range write");
    step(3'b000, 3'b000, 19'h04008, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R7 range kept, flag one cycle");
    step(3'b000, 3'b000, '0, allEn, 1'b1, 1'b1, 1'b1, 5'd0, "R7 restore default");
    step(3'b000, 3'b000, 19'h04008, allEn, 1'b0, 1'b1, 1'b0, 5'd0, "R5 default again");
    @(negedge clk);
    resetCause = '0; nmiReq = '0; maskReq = '0; wrEn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule